// File: doc/BRIEF.md
# LPDDR Clock Stop Controller

This block lives in the controller side of a mobile LPDDR memory interface and decides when the memory clock pair may be parked during idle stretches. It watches each command the controller issues, loads a single completion timer with the number of memory clock pulses that command still needs, which covers its timing window plus any burst data phase. Once a stop request arrives, it holds the command bus at NOP until the timer runs out. It then parks CK low and CK# high while CKE stays high throughout.

The memory clock is derived inside the block by toggling a register on every system clock edge, so one memory cycle spans two system clocks. A "rising CK edge" is a system edge at which CK goes from low to high. Commands are sampled only on those edges. Stopping and restarting happen only while CK is low, so no shortened pulse is ever produced. A wake request restarts the clock. The block forces NOP for at least one rising CK edge, plus a configurable number of extra ones, before it reports that access commands may flow again.

Top module: `ckstop_ctrl`

## Requirements
- R1: After reset the block is running with CK low, CK# high, stop_ack low, acc_ready high and force_nop low. CKE is high at all times.
- R2: While running, draining or resuming, CK toggles on every system clock edge, and CK# is always the complement of CK.
- R3: The command input is sampled only at rising CK edges while running. The encoding is NOP=0, ACTIVE=1, READ=2, WRITE=3, PRECHARGE=4, AUTO REFRESH=5, MODE REGISTER SET=6. NOP loads nothing.
- R4: The number of rising CK edges that follow a command's own edge before the clock is parked is fixed per command. With the defaults these are ACTIVE 3, READ 5 (CAS latency 3 plus burst 4/2), WRITE 5 (write latency 1 plus burst 4/2 plus write recovery 2), PRECHARGE 3, AUTO REFRESH 10, MODE REGISTER SET 2, and NOP 0.
- R5: Only the most recent accepted command sets the remaining wait. A newer command replaces the count left by an older one.
- R6: A stop request is ignored while bank_ok is low (memory neither idle nor row-active). The clock keeps toggling and stop_ack stays low.
- R7: Entry happens on the edge where CK falls. stop_ack rises on that same edge, and while stopped CK is held low and CK# high.
- R8: force_nop is high whenever the block is not running. Commands presented then are ignored and do not change the stop timing.
- R9: After wake, CK stays low for one system clock. force_nop is high at the first rising CK edge, and acc_ready returns after exactly 1+EXTRA_NOPS rising CK edges.
- R10: Withdrawing stop_req while draining returns the block to running without stopping the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the memory clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd | input | 3 | Command issued by the controller this memory cycle |
| bank_ok | input | 1 | Memory is idle or row-active |
| stop_req | input | 1 | Request to park the memory clock |
| wake | input | 1 | Request to restart a parked clock |
| ck | output | 1 | Memory clock, true phase |
| ck_n | output | 1 | Memory clock, complement phase |
| cke | output | 1 | Clock enable, held high |
| force_nop | output | 1 | Command bus must carry NOP |
| stop_ack | output | 1 | Clock is parked |
| acc_ready | output | 1 | Access commands may be issued |

## Verification
A command is taken at a system edge where CK rises, and stop_ack appears at the system edge where CK falls after the last counted pulse. The bench therefore counts CK low-to-high transitions, sampled on the falling system clock, from the command edge up to the sample where stop_ack is first seen. It compares that count with the figure computed from the timing parameters. After wake, the first sample shows CK still low with force_nop high, and the count of rises until acc_ready is compared with 1+EXTRA_NOPS. Commands are driven at a falling system edge while CK is low, so each one lands on exactly one rising CK edge.

// File: rtl/ckstop_pkg.sv
package ckstop_pkg;
   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_RD  = 3'd2,
      CMD_WR  = 3'd3,
      CMD_PRE = 3'd4,
      CMD_REF = 3'd5,
      CMD_MRS = 3'd6
   } cmd_e;

   typedef enum logic [1:0] {
      ST_RUN     = 2'd0,
      ST_DRAIN   = 2'd1,
      ST_STOPPED = 2'd2,
      ST_RESUME  = 2'd3
   } state_e;
endpackage

// File: rtl/ckstop_ckgen.sv
module ckstop_ckgen (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic ck_q,
   output logic tick
);
   // memory clock: toggles each system edge while running, parks low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ck_q <= 1'b0;
      else if (run) ck_q <= ~ck_q;
   end

   // next system edge is a rising CK edge
   assign tick = run & ~ck_q;
endmodule

// File: rtl/ckstop_timer.sv
module ckstop_timer
   import ckstop_pkg::*;
#(
   parameter int T_RCD     = 3,
   parameter int T_RP      = 3,
   parameter int T_RFC     = 10,
   parameter int T_MRD     = 2,
   parameter int T_WR      = 2,
   parameter int CAS_LAT   = 3,
   parameter int WR_LAT    = 1,
   parameter int BURST_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic load_en,
   input  cmd_e cmd,
   output logic zero
);
   localparam int BEATS_CYC = BURST_LEN / 2;
   localparam int RD_WAIT   = CAS_LAT + BEATS_CYC;
   localparam int WR_WAIT   = WR_LAT + BEATS_CYC + T_WR;
   localparam int MAX_A     = (T_RCD > T_RP) ? T_RCD : T_RP;
   localparam int MAX_B     = (T_RFC > T_MRD) ? T_RFC : T_MRD;
   localparam int MAX_C     = (RD_WAIT > WR_WAIT) ? RD_WAIT : WR_WAIT;
   localparam int MAX_AB    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int LOAD_MAX  = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
   localparam int CNT_W     = $clog2(LOAD_MAX + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_val;

   always_comb begin
      case (cmd)
         CMD_ACT: load_val = CNT_W'(T_RCD);
         CMD_RD:  load_val = CNT_W'(RD_WAIT);
         CMD_WR:  load_val = CNT_W'(WR_WAIT);
         CMD_PRE: load_val = CNT_W'(T_RP);
         CMD_REF: load_val = CNT_W'(T_RFC);
         CMD_MRS: load_val = CNT_W'(T_MRD);
         default: load_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_en && cmd != CMD_NOP)
         cnt_q <= load_val;
      else if (tick && cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/ckstop_fsm.sv
module ckstop_fsm
   import ckstop_pkg::*;
#(
   parameter int EXTRA_NOPS = 0
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   tick,
   input  logic   ck_q,
   input  logic   timer_zero,
   input  logic   stop_req,
   input  logic   bank_ok,
   input  logic   wake,
   output state_e state
);
   state_e state_d;
   logic   res_last;   // this rising edge completes the NOP count
   logic   res_load;

   assign res_load = (state == ST_STOPPED) && wake;

   generate
      if (EXTRA_NOPS == 0) begin : g_single_nop
         assign res_last = 1'b1;
      end else begin : g_nop_counter
         localparam int RES_W = $clog2(EXTRA_NOPS + 1);
         logic [RES_W-1:0] res_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               res_q <= '0;
            else if (res_load)
               res_q <= RES_W'(EXTRA_NOPS);
            else if (state == ST_RESUME && tick && res_q != '0)
               res_q <= res_q - 1'b1;
         end
         assign res_last = (res_q == '0);
      end
   endgenerate

   always_comb begin
      state_d = state;
      case (state)
         ST_RUN:     if (stop_req && bank_ok) state_d = ST_DRAIN;
         ST_DRAIN: begin
            if (!stop_req)                state_d = ST_RUN;
            else if (timer_zero && ck_q)  state_d = ST_STOPPED;
         end
         ST_STOPPED: if (wake) state_d = ST_RESUME;
         ST_RESUME:  if (tick && res_last) state_d = ST_RUN;
         default:    state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_RUN;
      else        state <= state_d;
   end
endmodule

// File: rtl/ckstop_ctrl.sv
module ckstop_ctrl
   import ckstop_pkg::*;
#(
   parameter int T_RCD      = 3,
   parameter int T_RP       = 3,
   parameter int T_RFC      = 10,
   parameter int T_MRD      = 2,
   parameter int T_WR       = 2,
   parameter int CAS_LAT    = 3,
   parameter int WR_LAT     = 1,
   parameter int BURST_LEN  = 4,
   parameter int EXTRA_NOPS = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] cmd,
   input  logic       bank_ok,
   input  logic       stop_req,
   input  logic       wake,
   output logic       ck,
   output logic       ck_n,
   output logic       cke,
   output logic       force_nop,
   output logic       stop_ack,
   output logic       acc_ready
);
   generate
      if (BURST_LEN != 2 && BURST_LEN != 4 && BURST_LEN != 8 && BURST_LEN != 16) begin : g_bad_bl
         $error("ckstop_ctrl: BURST_LEN must be 2, 4, 8 or 16");
      end
      if (T_RCD < 1 || T_RP < 1 || T_RFC < 1 || T_MRD < 1 || T_WR < 0) begin : g_bad_t
         $error("ckstop_ctrl: timing windows out of range");
      end
      if (CAS_LAT < 1 || WR_LAT < 0 || EXTRA_NOPS < 0) begin : g_bad_lat
         $error("ckstop_ctrl: latency or EXTRA_NOPS out of range");
      end
   endgenerate

   state_e state_q;
   logic   ck_q, tick, timer_zero, run, load_en;

   assign run     = (state_q != ST_STOPPED);
   assign load_en = tick && (state_q == ST_RUN);

   ckstop_ckgen u_ckgen (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .ck_q  (ck_q),
      .tick  (tick)
   );

   ckstop_timer #(
      .T_RCD     (T_RCD),
      .T_RP      (T_RP),
      .T_RFC     (T_RFC),
      .T_MRD     (T_MRD),
      .T_WR      (T_WR),
      .CAS_LAT   (CAS_LAT),
      .WR_LAT    (WR_LAT),
      .BURST_LEN (BURST_LEN)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .load_en (load_en),
      .cmd     (cmd_e'(cmd)),
      .zero    (timer_zero)
   );

   ckstop_fsm #(
      .EXTRA_NOPS (EXTRA_NOPS)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .ck_q       (ck_q),
      .timer_zero (timer_zero),
      .stop_req   (stop_req),
      .bank_ok    (bank_ok),
      .wake       (wake),
      .state      (state_q)
   );

   assign ck        = ck_q;
   assign ck_n      = ~ck_q;
   assign cke       = 1'b1;
   assign force_nop = (state_q != ST_RUN);
   assign stop_ack  = (state_q == ST_STOPPED);
   assign acc_ready = (state_q == ST_RUN);
endmodule

// File: rtl/ckstop_ctrl_chk.sv
module ckstop_ctrl_chk
   import ckstop_pkg::*;
(
   input logic   clk,
   input logic   rst_n,
   input state_e state_q,
   input logic   timer_zero,
   input logic   ck,
   input logic   ck_n,
   input logic   force_nop,
   input logic   stop_ack,
   input logic   acc_ready
);
   assert_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN) |=> (ck != $past(ck)));

   assert_parked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_STOPPED) |-> (!ck && ck_n));

   assert_entry_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stop_ack) |-> $fell(ck));

   assert_drained_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stop_ack) |-> timer_zero);

   assert_nop_while_parked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ack |-> force_nop);

   assert_wake_nop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stop_ack) |-> (!acc_ready && force_nop && !ck));
endmodule

bind ckstop_ctrl ckstop_ctrl_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .state_q    (state_q),
   .timer_zero (timer_zero),
   .ck         (ck),
   .ck_n       (ck_n),
   .force_nop  (force_nop),
   .stop_ack   (stop_ack),
   .acc_ready  (acc_ready)
);

// File: tb/ckstop_ctrl_tb_top.sv
`timescale 1ns/1ps
module ckstop_ctrl_tb_top;
   localparam int T_RCD = 3, T_RP = 3, T_RFC = 10, T_MRD = 2, T_WR = 2;
   localparam int CAS_LAT = 3, WR_LAT = 1, BURST_LEN = 4, EXTRA_NOPS = 0;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cmd = 3'd0;
   logic       bank_ok = 1'b1;
   logic       stop_req = 1'b0;
   logic       wake = 1'b0;
   logic       ck, ck_n, cke, force_nop, stop_ack, acc_ready;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   ckstop_ctrl #(
      .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD), .T_WR(T_WR),
      .CAS_LAT(CAS_LAT), .WR_LAT(WR_LAT), .BURST_LEN(BURST_LEN), .EXTRA_NOPS(EXTRA_NOPS)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank_ok(bank_ok),
      .stop_req(stop_req), .wake(wake), .ck(ck), .ck_n(ck_n), .cke(cke),
      .force_nop(force_nop), .stop_ack(stop_ack), .acc_ready(acc_ready)
   );

   function automatic int exp_wait(input int c);
      case (c)
         1: return T_RCD;
         2: return CAS_LAT + BURST_LEN / 2;
         3: return WR_LAT + BURST_LEN / 2 + T_WR;
         4: return T_RP;
         5: return T_RFC;
         6: return T_MRD;
         default: return 0;
      endcase
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // drive a command so that it lands on exactly one rising CK edge
   task automatic issue(input int c, input bit with_stop);
      @(negedge clk);
      if (ck) @(negedge clk);
      cmd = 3'(c);
      if (with_stop) stop_req = 1'b1;
      @(posedge clk);
      #1 cmd = 3'd0;
   endtask

   // count CK rises until stop_ack (want_ready=0) or acc_ready (want_ready=1)
   task automatic count_rises(input bit want_ready, output int n);
      logic prev;
      bit   hit;
      prev = ck;
      n = 0;
      hit = 1'b0;
      for (int k = 0; k < 400 && !hit; k++) begin
         @(negedge clk);
         if (ck && !prev) n++;
         prev = ck;
         hit = want_ready ? acc_ready : stop_ack;
      end
      if (!hit) n = -1;
   endtask

   task automatic park_and_wake(input string tag);
      int n;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check({"R7 parked ck ", tag}, int'(ck), 0);
         check({"R7 parked ck_n ", tag}, int'(ck_n), 1);
         check({"R1 cke ", tag}, int'(cke), 1);
         check({"R8 force_nop ", tag}, int'(force_nop), 1);
      end
      stop_req = 1'b0;
      wake = 1'b1;
      @(posedge clk);
      #1 wake = 1'b0;
      @(negedge clk);
      check({"R9 ck low after wake ", tag}, int'(ck), 0);
      check({"R9 nop before first rise ", tag}, int'(force_nop), 1);
      check({"R9 not ready ", tag}, int'(acc_ready), 0);
      count_rises(1'b1, n);
      check({"R9 rises to ready ", tag}, n, 1 + EXTRA_NOPS);
   endtask

   initial begin
      #(200000 * 10);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int n;
      logic prev;
      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1 ck", int'(ck), 0);
      check("R1 ck_n", int'(ck_n), 1);
      check("R1 cke", int'(cke), 1);
      check("R1 stop_ack", int'(stop_ack), 0);
      check("R1 acc_ready", int'(acc_ready), 1);
      check("R1 force_nop", int'(force_nop), 0);
      rst_n = 1'b1;

      // R2 toggling while running
      @(negedge clk);
      prev = ck;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         check("R2 toggle", int'(ck), int'(!prev));
         check("R2 complement", int'(ck_n), int'(!ck));
         prev = ck;
      end

      // R3/R4 sweep every command code
      for (int c = 0; c < 7; c++) begin
         issue(c, 1'b1);
         count_rises(1'b0, n);
         check($sformatf("R4 R3 wait for cmd %0d", c), n, exp_wait(c));
         park_and_wake($sformatf("cmd%0d", c));
      end

      // R5 newest command decides the wait
      issue(5, 1'b0);
      issue(6, 1'b1);
      count_rises(1'b0, n);
      check("R5 newest command", n, exp_wait(6));
      park_and_wake("R5");

      // R8 command during drain is ignored
      issue(1, 1'b1);
      cmd = 3'd5;
      count_rises(1'b0, n);
      cmd = 3'd0;
      check("R8 drain ignores cmd", n, exp_wait(1));
      park_and_wake("R8");

      // R6 stop refused while banks not idle/active
      bank_ok = 1'b0;
      stop_req = 1'b1;
      n = 0;
      @(negedge clk);
      prev = ck;
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         if (stop_ack) n = 99;
         if (ck && !prev && n != 99) n++;
         prev = ck;
      end
      check("R6 clock keeps running", n, 15);
      check("R6 ready stays", int'(acc_ready), 1);
      stop_req = 1'b0;
      bank_ok = 1'b1;

      // R10 withdraw during drain
      issue(5, 1'b1);
      repeat (4) @(negedge clk);
      check("R10 draining", int'(force_nop), 1);
      stop_req = 1'b0;
      repeat (2) @(negedge clk);
      check("R10 back to run", int'(acc_ready), 1);
      check("R10 no ack", int'(stop_ack), 0);
      repeat (30) @(negedge clk);
      check("R10 still no ack", int'(stop_ack), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule